// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects thirty-two raw interrupt inputs, conditions each one according to its own mode (active-high level, active-low level, rising edge or falling edge), and presents the processor with a single request line for the most urgent source that is both pending and enabled. Every source has a three-bit priority and a software-chosen vector word. Software talks to the block over a simple word-addressed read/write strobe bus.

Servicing follows a fixed pattern. The handler reads the vector register, which returns the winning source's vector and at the same time acknowledges it. The acknowledge records the source's priority and number on an eight-level nesting stack and clears a latched edge. While a level sits on the stack, only sources of strictly higher priority may raise the request. A write of any value to the end-of-interrupt register removes one level. When nothing qualifies, the vector read returns a programmable spurious vector and has no side effect. A debug register provides a protect mode, in which reads of the vector register have no side effect and the acknowledge comes from a write to that register instead. The same register also holds a general mask that silences the request line.

Top module: `pvic_top`

## Requirements
- R1: After reset the enable mask is all zero, the nesting stack is empty, the request output is low, and every mode, vector, spurious and debug register reads zero.
- R2: The mode register of source n sits at byte offset 4n; priority is bits [2:0] (0 lowest, 7 highest) and the kind is bits [6:5] with 00 = low level, 01 = falling edge, 10 = high level, 11 = rising edge; a read returns those two fields and zero elsewhere.
- R3: A level-kind source shows pending (offset 0x10C, bit n) exactly while its input is at the active level, with no latching.
- R4: An edge-kind source latches pending on its chosen edge and holds it until acknowledged or until a one is written to its bit at the clear-command offset 0x128.
- R5: Writing ones to offset 0x120 sets enable bits and writing ones to 0x124 clears them; zero bits have no effect; offset 0x110 reads the enable mask.
- R6: Writing ones to offset 0x12C forces pending bits, which stay until acknowledged or cleared through 0x128.
- R7: The request output is high exactly when some pending, enabled source has a priority above the top stack level (any priority when the stack is empty); among those the highest priority wins, and on a tie the lowest source number.
- R8: A read of offset 0x100 returns the winner's vector (vector registers at 0x80 + 4n) and acknowledges it: its priority and number are pushed, and its latched pending bit is cleared; offset 0x108 reads the number of the source on top of the stack, zero when empty.
- R9: With no winner, a read of 0x100 returns the spurious vector register (offset 0x134) and leaves the stack unchanged.
- R10: Each write of any value to 0x130 pops one level, up to eight nested levels; such a write with an empty stack has no effect.
- R11: Debug register 0x138 bit 0 selects protect mode: a read of 0x100 returns the vector without acknowledging, and a write to 0x100 performs the acknowledge.
- R12: Debug register bit 1 is a general mask: while set the request output is low and a read of 0x100 returns the spurious vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src_i | input | 32 | Raw interrupt inputs, one per source |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_addr_i | input | 9 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_req_o | output | 1 | Interrupt request to the processor, active high |

## Verification
The hardest state to reach is a full eight-level nest, because each level can only be entered by a source whose priority is strictly above every level already stacked. The bench builds it on purpose. It gives eight sources the priorities 0 to 7 and, one at a time in ascending order, forces each one pending and acknowledges it. It then checks that the request stays low even with a lower source pending, and unwinds the stack with end-of-interrupt writes, checking the stacked source number after every pop. A long random phase then interleaves input toggles, mode rewrites, enable changes, forced and cleared pending bits, acknowledges and end-of-interrupt writes, with occasional protect and mask mode. Every read and the request line are compared against a bench model.

// File: rtl/pvic_pkg.sv
// Shared definitions for the prioritized vectored interrupt controller.
// Assumes: byte addressing, 32-bit word registers, at most 32 sources.
package pvic_pkg;

    // Source conditioning kinds, as encoded in the mode register.
    typedef enum logic [1:0] {
        KIND_LOW  = 2'b00,
        KIND_FALL = 2'b01,
        KIND_HIGH = 2'b10,
        KIND_RISE = 2'b11
    } src_kind_e;

    // Register byte offsets.
    localparam int OFS_VEC_BASE = 'h080;
    localparam int OFS_IVR      = 'h100;
    localparam int OFS_CUR_SRC  = 'h108;
    localparam int OFS_PENDING  = 'h10C;
    localparam int OFS_ENABLED  = 'h110;
    localparam int OFS_EN_SET   = 'h120;
    localparam int OFS_EN_CLR   = 'h124;
    localparam int OFS_PND_CLR  = 'h128;
    localparam int OFS_PND_SET  = 'h12C;
    localparam int OFS_EOI      = 'h130;
    localparam int OFS_SPUR     = 'h134;
    localparam int OFS_DEBUG    = 'h138;

    // Mode register field positions.
    localparam int MODE_PRI_LSB  = 0;
    localparam int MODE_KIND_LSB = 5;

endpackage

// File: rtl/pvic_cond.sv
// Per-source input conditioning.
// Turns each raw input into a pending bit according to its kind: level kinds
// follow the input directly, edge kinds latch on the chosen edge. A software
// set, a software clear and an acknowledge act on the latch for every kind.
// Assumes: raw inputs are already synchronous to clk. A set and a new edge
// take precedence over a clear or an acknowledge in the same cycle.
module pvic_cond
    import pvic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      raw_i,
    input  logic [NUM_SRC-1:0][1:0] kind_i,
    input  logic [NUM_SRC-1:0]      set_i,
    input  logic [NUM_SRC-1:0]      clr_i,
    input  logic [NUM_SRC-1:0]      ack_i,
    output logic [NUM_SRC-1:0]      pend_o
);

    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] latch_q;

    // Previous input sample; tracked through reset so no edge appears on release.
    always_ff @(posedge clk) begin
        prev_q <= raw_i;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic edge_hit;
        logic level_hit;

        // Edge detect for the selected edge kind.
        always_comb begin
            if (kind_i[i] == KIND_RISE)      edge_hit = raw_i[i] & ~prev_q[i];
            else if (kind_i[i] == KIND_FALL) edge_hit = ~raw_i[i] & prev_q[i];
            else                             edge_hit = 1'b0;
        end

        // Level kinds: active when the input sits at the selected level.
        always_comb begin
            if (kind_i[i] == KIND_HIGH)     level_hit = raw_i[i];
            else if (kind_i[i] == KIND_LOW) level_hit = ~raw_i[i];
            else                            level_hit = 1'b0;
        end

        // Latched pending: set by edge or software, cleared by clear or acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)                     latch_q[i] <= 1'b0;
            else if (edge_hit || set_i[i])  latch_q[i] <= 1'b1;
            else if (clr_i[i] || ack_i[i])  latch_q[i] <= 1'b0;
        end

        assign pend_o[i] = latch_q[i] | level_hit;
    end

endmodule

// File: rtl/pvic_arb.sv
// Priority arbiter.
// Picks, among candidate sources whose priority is above the current floor,
// the one of highest priority; ties go to the lowest source number.
// Assumes: floor_en_i low means no level is active and every priority qualifies.
module pvic_arb #(
    parameter int NUM_SRC = 32,
    parameter int PRI_W   = 3,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            cand_i,
    input  logic [NUM_SRC-1:0][PRI_W-1:0] pri_i,
    input  logic                          floor_en_i,
    input  logic [PRI_W-1:0]              floor_i,
    output logic                          win_valid_o,
    output logic [IDX_W-1:0]              win_idx_o,
    output logic [PRI_W-1:0]              win_pri_o
);

    // Linear scan; strict comparison keeps the lowest number on a tie.
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_pri_o   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand_i[i] && (!floor_en_i || pri_i[i] > floor_i) &&
                (!win_valid_o || pri_i[i] > win_pri_o)) begin
                win_valid_o = 1'b1;
                win_idx_o   = IDX_W'(i);
                win_pri_o   = pri_i[i];
            end
        end
    end

endmodule

// File: rtl/pvic_stack.sv
// Nesting stack of acknowledged interrupts.
// Each entry holds the priority and source number of an acknowledged
// interrupt; the top entry sets the arbitration floor.
// Assumes: push and pop never arrive in the same cycle; a push when full and
// a pop when empty are ignored.
module pvic_stack #(
    parameter int DEPTH  = 8,
    parameter int PRI_W  = 3,
    parameter int IDX_W  = 5,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [PRI_W-1:0] push_pri_i,
    input  logic [IDX_W-1:0] push_idx_i,
    input  logic             pop_i,
    output logic             empty_o,
    output logic [PRI_W-1:0] top_pri_o,
    output logic [IDX_W-1:0] top_idx_o,
    output logic [CNT_W-1:0] depth_o
);

    logic [PRI_W-1:0] pri_q [DEPTH];
    logic [IDX_W-1:0] idx_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_cnt;
    logic             full;

    assign empty_o = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign top_cnt = cnt_q - CNT_W'(1);
    assign depth_o = cnt_q;

    // Occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (push_i && !full)    cnt_q <= cnt_q + CNT_W'(1);
        else if (pop_i && !empty_o)  cnt_q <= cnt_q - CNT_W'(1);
    end

    // Entry storage, written at the free slot on a push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pri_q[i] <= '0;
                idx_q[i] <= '0;
            end
        end else if (push_i && !full) begin
            pri_q[cnt_q[PTR_W-1:0]] <= push_pri_i;
            idx_q[cnt_q[PTR_W-1:0]] <= push_idx_i;
        end
    end

    // Top of stack view; zero when empty.
    always_comb begin
        top_pri_o = empty_o ? '0 : pri_q[top_cnt[PTR_W-1:0]];
        top_idx_o = empty_o ? '0 : idx_q[top_cnt[PTR_W-1:0]];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full);                                                   // R10
    AST_NEST_STRICTLY_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && !empty_o |-> push_pri_i > top_pri_o);                      // R7
    AST_POP_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !push_i && !empty_o |=> depth_o == $past(depth_o) - CNT_W'(1)); // R10

endmodule

// File: rtl/pvic_top.sv
// Prioritized vectored interrupt controller, top level.
// Holds the register file, decodes the strobe bus, conditions the sources,
// arbitrates by priority and manages the acknowledge / end-of-interrupt nest.
// Assumes: NUM_SRC <= 32 and DATA_W >= NUM_SRC; word-aligned accesses only;
// bus_rd_i and bus_wr_i are never high together; read data is combinational.
module pvic_top
    import pvic_pkg::*;
#(
    parameter int NUM_SRC    = 32,
    parameter int PRI_W      = 3,
    parameter int NEST_DEPTH = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_req_o
);

    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int CNT_W = $clog2(NEST_DEPTH + 1);

    localparam logic [ADDR_W-1:0] A_VEC_BASE = ADDR_W'(OFS_VEC_BASE);
    localparam logic [ADDR_W-1:0] A_VEC_END  = ADDR_W'(OFS_VEC_BASE + NUM_SRC * 4);
    localparam logic [ADDR_W-1:0] A_MODE_END = ADDR_W'(NUM_SRC * 4);
    localparam logic [ADDR_W-1:0] A_IVR      = ADDR_W'(OFS_IVR);
    localparam logic [ADDR_W-1:0] A_CUR_SRC  = ADDR_W'(OFS_CUR_SRC);
    localparam logic [ADDR_W-1:0] A_PENDING  = ADDR_W'(OFS_PENDING);
    localparam logic [ADDR_W-1:0] A_ENABLED  = ADDR_W'(OFS_ENABLED);
    localparam logic [ADDR_W-1:0] A_EN_SET   = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_EN_CLR   = ADDR_W'(OFS_EN_CLR);
    localparam logic [ADDR_W-1:0] A_PND_CLR  = ADDR_W'(OFS_PND_CLR);
    localparam logic [ADDR_W-1:0] A_PND_SET  = ADDR_W'(OFS_PND_SET);
    localparam logic [ADDR_W-1:0] A_EOI      = ADDR_W'(OFS_EOI);
    localparam logic [ADDR_W-1:0] A_SPUR     = ADDR_W'(OFS_SPUR);
    localparam logic [ADDR_W-1:0] A_DEBUG    = ADDR_W'(OFS_DEBUG);

    // Register file state.
    logic [NUM_SRC-1:0][PRI_W-1:0] mode_pri_q;
    logic [NUM_SRC-1:0][1:0]       mode_kind_q;
    logic [DATA_W-1:0]             vec_q [NUM_SRC];
    logic [NUM_SRC-1:0]            enable_q;
    logic [DATA_W-1:0]             spur_q;
    logic                          prot_q;
    logic                          gmask_q;

    // Decode.
    logic             aligned, is_mode, is_vec;
    logic [IDX_W-1:0] sel_idx;
    logic             ivr_rd, ivr_wr, eoi_wr;
    logic [NUM_SRC-1:0] set_mask, clr_mask, ack_mask;

    // Arbitration and nest.
    logic [NUM_SRC-1:0] pend;
    logic               win_valid, win_ok, ack_fire;
    logic [IDX_W-1:0]   win_idx;
    logic [PRI_W-1:0]   win_pri;
    logic               stk_empty;
    logic [PRI_W-1:0]   stk_pri;
    logic [IDX_W-1:0]   stk_idx;
    logic [CNT_W-1:0]   stk_depth;

    // Address decode of the per-source windows and the command strobes.
    always_comb begin
        aligned  = (bus_addr_i[1:0] == 2'b00);
        is_mode  = aligned && (bus_addr_i < A_MODE_END);
        is_vec   = aligned && (bus_addr_i >= A_VEC_BASE) && (bus_addr_i < A_VEC_END);
        sel_idx  = bus_addr_i[IDX_W+1:2];
        ivr_rd   = bus_rd_i && (bus_addr_i == A_IVR);
        ivr_wr   = bus_wr_i && (bus_addr_i == A_IVR);
        eoi_wr   = bus_wr_i && (bus_addr_i == A_EOI);
        set_mask = (bus_wr_i && bus_addr_i == A_PND_SET) ? bus_wdata_i[NUM_SRC-1:0] : '0;
        clr_mask = (bus_wr_i && bus_addr_i == A_PND_CLR) ? bus_wdata_i[NUM_SRC-1:0] : '0;
    end

    pvic_cond #(
        .NUM_SRC (NUM_SRC)
    ) u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (irq_src_i),
        .kind_i (mode_kind_q),
        .set_i  (set_mask),
        .clr_i  (clr_mask),
        .ack_i  (ack_mask),
        .pend_o (pend)
    );

    pvic_arb #(
        .NUM_SRC (NUM_SRC),
        .PRI_W   (PRI_W)
    ) u_arb (
        .cand_i      (pend & enable_q),
        .pri_i       (mode_pri_q),
        .floor_en_i  (!stk_empty),
        .floor_i     (stk_pri),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_pri_o   (win_pri)
    );

    // Request and acknowledge qualification.
    always_comb begin
        win_ok    = win_valid && !gmask_q;
        irq_req_o = win_ok;
        ack_fire  = win_ok && (prot_q ? ivr_wr : ivr_rd);
        ack_mask  = ack_fire ? (NUM_SRC'(1) << win_idx) : '0;
    end

    pvic_stack #(
        .DEPTH (NEST_DEPTH),
        .PRI_W (PRI_W),
        .IDX_W (IDX_W)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (ack_fire),
        .push_pri_i (win_pri),
        .push_idx_i (win_idx),
        .pop_i      (eoi_wr),
        .empty_o    (stk_empty),
        .top_pri_o  (stk_pri),
        .top_idx_o  (stk_idx),
        .depth_o    (stk_depth)
    );

    // Register writes: modes, vectors, enable commands, spurious and debug.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_pri_q  <= '0;
            mode_kind_q <= '0;
            for (int i = 0; i < NUM_SRC; i++) vec_q[i] <= '0;
            enable_q    <= '0;
            spur_q      <= '0;
            prot_q      <= 1'b0;
            gmask_q     <= 1'b0;
        end else if (bus_wr_i) begin
            if (is_mode) begin
                mode_pri_q[sel_idx]  <= bus_wdata_i[MODE_PRI_LSB +: PRI_W];
                mode_kind_q[sel_idx] <= bus_wdata_i[MODE_KIND_LSB +: 2];
            end
            if (is_vec) vec_q[sel_idx] <= bus_wdata_i;
            if (bus_addr_i == A_EN_SET) enable_q <= enable_q | bus_wdata_i[NUM_SRC-1:0];
            if (bus_addr_i == A_EN_CLR) enable_q <= enable_q & ~bus_wdata_i[NUM_SRC-1:0];
            if (bus_addr_i == A_SPUR)   spur_q   <= bus_wdata_i;
            if (bus_addr_i == A_DEBUG) begin
                prot_q  <= bus_wdata_i[0];
                gmask_q <= bus_wdata_i[1];
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata_o = '0;
        if (is_mode) begin
            bus_rdata_o[MODE_PRI_LSB +: PRI_W] = mode_pri_q[sel_idx];
            bus_rdata_o[MODE_KIND_LSB +: 2]    = mode_kind_q[sel_idx];
        end else if (is_vec) begin
            bus_rdata_o = vec_q[sel_idx];
        end else begin
            case (bus_addr_i)
                A_IVR:     bus_rdata_o = win_ok ? vec_q[win_idx] : spur_q;
                A_CUR_SRC: bus_rdata_o = DATA_W'(stk_idx);
                A_PENDING: bus_rdata_o = DATA_W'(pend);
                A_ENABLED: bus_rdata_o = DATA_W'(enable_q);
                A_SPUR:    bus_rdata_o = spur_q;
                A_DEBUG:   bus_rdata_o = DATA_W'({gmask_q, prot_q});
                default:   bus_rdata_o = '0;
            endcase
        end
    end

    AST_PROTECT_READ_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ivr_rd && prot_q |=> stk_depth == $past(stk_depth));                  // R11
    AST_SPURIOUS_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ivr_rd && !win_ok |=> stk_depth == $past(stk_depth));                 // R9
    AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> stk_depth == $past(stk_depth) + CNT_W'(1));              // R8
    AST_REQ_ABOVE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o && !stk_empty |-> win_pri > stk_pri);                       // R7
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_i && bus_wr_i));                                             // R8

endmodule

// File: tb/tb_pvic_top.sv
`timescale 1ns/1ps
module tb_pvic_top;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    pvic_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_src_i   (src),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_req_o   (irq)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Bench model of the register-visible state.
    logic [2:0]  m_pri  [N];
    logic [1:0]  m_kind [N];
    logic [31:0] m_vec  [N];
    logic [31:0] m_en, m_lat, m_prev, m_spu;
    logic        m_prot, m_gm;
    logic [2:0]  s_pri [8];
    logic [4:0]  s_idx [8];
    int          m_depth;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] f_pend();
        logic [31:0] p;
        for (int i = 0; i < N; i++)
            p[i] = m_lat[i] | (m_kind[i] == 2'b10 && src[i]) | (m_kind[i] == 2'b00 && !src[i]);
        return p;
    endfunction

    function automatic int f_winner();
        logic [31:0] p = f_pend();
        int best = -1;
        logic [2:0] bp = 0;
        for (int i = 0; i < N; i++)
            if (p[i] && m_en[i] && (m_depth == 0 || m_pri[i] > s_pri[m_depth-1]) &&
                (best < 0 || m_pri[i] > bp)) begin
                best = i;
                bp   = m_pri[i];
            end
        return best;
    endfunction

    function automatic logic f_valid();
        return (f_winner() >= 0) && !m_gm;
    endfunction

    function automatic logic [31:0] f_read(input logic [8:0] a);
        if (a[1:0] != 0) return 0;
        if (a < 9'h080) return 32'(m_pri[a[6:2]]) | (32'(m_kind[a[6:2]]) << 5);
        if (a < 9'h100) return m_vec[a[6:2]];
        case (a)
            9'h100: return f_valid() ? m_vec[f_winner()] : m_spu;
            9'h108: return (m_depth > 0) ? 32'(s_idx[m_depth-1]) : 0;
            9'h10C: return f_pend();
            9'h110: return m_en;
            9'h134: return m_spu;
            9'h138: return {30'b0, m_gm, m_prot};
            default: return 0;
        endcase
    endfunction

    // Advance the model by one clock using the inputs now on the pins.
    task automatic model_clock();
        int w = f_winner();
        logic ok = (w >= 0) && !m_gm;
        logic ack = ok && (m_prot ? (wr && addr == 9'h100) : (rd && addr == 9'h100));
        logic [31:0] nl;
        for (int i = 0; i < N; i++) begin
            logic e = (m_kind[i] == 2'b11 && src[i] && !m_prev[i]) ||
                      (m_kind[i] == 2'b01 && !src[i] && m_prev[i]);
            logic s = e || (wr && addr == 9'h12C && wdata[i]);
            logic c = (wr && addr == 9'h128 && wdata[i]) || (ack && w == i);
            nl[i] = s ? 1'b1 : (c ? 1'b0 : m_lat[i]);
        end
        m_lat  = nl;
        m_prev = src;
        if (ack) begin
            s_pri[m_depth] = m_pri[w];
            s_idx[m_depth] = 5'(w);
            m_depth++;
        end else if (wr && addr == 9'h130 && m_depth > 0) begin
            m_depth--;
        end
        if (wr) begin
            if (addr < 9'h080 && addr[1:0] == 0) begin
                m_pri[addr[6:2]]  = wdata[2:0];
                m_kind[addr[6:2]] = wdata[6:5];
            end else if (addr < 9'h100 && addr[1:0] == 0) begin
                m_vec[addr[6:2]] = wdata;
            end
            case (addr)
                9'h120: m_en = m_en | wdata;
                9'h124: m_en = m_en & ~wdata;
                9'h134: m_spu = wdata;
                9'h138: begin m_prot = wdata[0]; m_gm = wdata[1]; end
                default: ;
            endcase
        end
    endtask

    task automatic tick();
        model_clock();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [8:0] a, input string req, output logic [31:0] v);
        rd = 1'b1; addr = a;
        #1;
        v = rdata;
        check(rdata, f_read(a), req);
        tick();
        rd = 1'b0;
    endtask

    task automatic chk_irq(input string req);
        #1;
        check(32'(irq), 32'(f_valid()), req);
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin m_pri[i] = 0; m_kind[i] = 0; m_vec[i] = 0; end
        for (int i = 0; i < 8; i++) begin s_pri[i] = 0; s_idx[i] = 0; end
        m_en = 0; m_lat = 0; m_prev = src; m_spu = 0; m_prot = 0; m_gm = 0; m_depth = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_reset();

        // R1: reset state
        #1 check(32'(irq), 0, "R1");
        bus_read(9'h110, "R1", v); check(v, 32'h0, "R1");
        bus_read(9'h108, "R1", v); check(v, 32'h0, "R1");
        bus_read(9'h100, "R1", v); check(v, 32'h0, "R1");
        bus_read(9'h10C, "R1", v); check(v, 32'hFFFF_FFFF, "R1");
        bus_read(9'h00C, "R1", v); check(v, 32'h0, "R1");

        // Program vectors, spurious value and high-level modes.
        bus_write(9'h134, 32'h0000_0BAD);
        for (int n = 0; n < N; n++) begin
            bus_write(9'(9'h080 + n * 4), 32'hA000_0000 | n);
            bus_write(9'(n * 4), 32'h40 | (n % 8));
        end
        bus_read(9'h08C, "R8", v); check(v, 32'hA000_0003, "R8");

        // R2: mode fields and read-back masking
        bus_write(9'h014, 32'h0000_0065);
        bus_read(9'h014, "R2", v); check(v, 32'h65, "R2");
        bus_write(9'h014, 32'hFFFF_FFFF);
        bus_read(9'h014, "R2", v); check(v, 32'h67, "R2");
        bus_write(9'h014, 32'h45);

        // R5: enable set/clear with zero bits inert
        bus_write(9'h120, 32'hF0);
        bus_read(9'h110, "R5", v); check(v, 32'hF0, "R5");
        bus_write(9'h120, 32'h0);
        bus_read(9'h110, "R5", v); check(v, 32'hF0, "R5");
        bus_write(9'h124, 32'h10);
        bus_read(9'h110, "R5", v); check(v, 32'hE0, "R5");
        bus_write(9'h124, 32'h0);
        bus_read(9'h110, "R5", v); check(v, 32'hE0, "R5");
        bus_write(9'h124, 32'hFFFF_FFFF);

        // R3: level sources follow the input
        src[3] = 1'b1;
        bus_read(9'h10C, "R3", v); check(v & 32'h8, 32'h8, "R3");
        src[3] = 1'b0;
        bus_read(9'h10C, "R3", v); check(v & 32'h8, 32'h0, "R3");
        bus_write(9'h018, 32'h00);
        bus_read(9'h10C, "R3", v); check(v & 32'h40, 32'h40, "R3");
        bus_write(9'h018, 32'h40);

        // R4: rising and falling edge latch, then clear command
        bus_write(9'h010, 32'h62);
        src[4] = 1'b1; tick(); src[4] = 1'b0; tick(); tick();
        bus_read(9'h10C, "R4", v); check(v & 32'h10, 32'h10, "R4");
        bus_write(9'h128, 32'h10);
        bus_read(9'h10C, "R4", v); check(v & 32'h10, 32'h0, "R4");
        bus_write(9'h024, 32'h21);
        src[9] = 1'b1; tick();
        bus_read(9'h10C, "R4", v); check(v & 32'h200, 32'h0, "R4");
        src[9] = 1'b0; tick();
        bus_read(9'h10C, "R4", v); check(v & 32'h200, 32'h200, "R4");
        bus_write(9'h128, 32'h200);
        bus_write(9'h024, 32'h41);

        // R6: software set and clear
        bus_write(9'h12C, 32'h400);
        bus_read(9'h10C, "R6", v); check(v & 32'h400, 32'h400, "R6");
        bus_write(9'h128, 32'h400);
        bus_read(9'h10C, "R6", v); check(v & 32'h400, 32'h0, "R6");

        // R7 tie break and R8 acknowledge, with floor blocking the equal priority
        bus_write(9'h02C, 32'h44);
        bus_write(9'h030, 32'h44);
        bus_write(9'h120, 32'h1800);
        bus_write(9'h12C, 32'h1800);
        chk_irq("R7"); check(32'(irq), 1, "R7");
        bus_read(9'h100, "R8", v); check(v, 32'hA000_000B, "R8");
        bus_read(9'h108, "R8", v); check(v, 32'd11, "R8");
        chk_irq("R7"); check(32'(irq), 0, "R7");
        bus_write(9'h130, 32'h0);
        chk_irq("R7"); check(32'(irq), 1, "R7");
        bus_read(9'h100, "R8", v); check(v, 32'hA000_000C, "R8");
        bus_write(9'h130, 32'h1234);

        // R9: spurious read leaves the nest alone
        bus_read(9'h100, "R9", v); check(v, 32'h0000_0BAD, "R9");
        bus_read(9'h108, "R9", v); check(v, 32'h0, "R9");

        // R10: build the full eight-level nest and unwind it
        bus_write(9'h124, 32'hFFFF_FFFF);
        bus_write(9'h128, 32'hFFFF_FFFF);
        for (int k = 0; k < 8; k++) bus_write(9'((20 + k) * 4), 32'h40 | k);
        bus_write(9'h120, 32'h0FF0_0000);
        for (int k = 0; k < 8; k++) begin
            bus_write(9'h12C, 32'h1 << (20 + k));
            bus_read(9'h100, "R10", v); check(v, 32'hA000_0000 | (20 + k), "R10");
        end
        bus_write(9'h12C, 32'h0010_0000);
        chk_irq("R10"); check(32'(irq), 0, "R10");
        for (int j = 0; j < 8; j++) begin
            bus_read(9'h108, "R10", v); check(v, 32'(27 - j), "R10");
            bus_write(9'h130, 32'h0);
        end
        bus_read(9'h108, "R10", v); check(v, 32'h0, "R10");
        chk_irq("R10"); check(32'(irq), 1, "R10");
        bus_write(9'h130, 32'h0);
        bus_read(9'h108, "R10", v); check(v, 32'h0, "R10");
        bus_read(9'h100, "R10", v); check(v, 32'hA000_0014, "R10");
        bus_write(9'h130, 32'h0);

        // R11: protect mode
        bus_write(9'h138, 32'h1);
        bus_write(9'h120, 32'h800);
        bus_write(9'h12C, 32'h800);
        bus_read(9'h100, "R11", v); check(v, 32'hA000_000B, "R11");
        bus_read(9'h100, "R11", v); check(v, 32'hA000_000B, "R11");
        bus_read(9'h108, "R11", v); check(v, 32'h0, "R11");
        bus_write(9'h100, 32'h0);
        bus_read(9'h108, "R11", v); check(v, 32'd11, "R11");
        bus_write(9'h130, 32'h0);
        bus_write(9'h138, 32'h0);

        // R12: general mask
        bus_write(9'h138, 32'h2);
        bus_write(9'h120, 32'h1000);
        bus_write(9'h12C, 32'h1000);
        chk_irq("R12"); check(32'(irq), 0, "R12");
        bus_read(9'h100, "R12", v); check(v, 32'h0000_0BAD, "R12");
        bus_write(9'h138, 32'h0);
        chk_irq("R12"); check(32'(irq), 1, "R12");
        bus_read(9'h100, "R12", v);
        bus_write(9'h130, 32'h0);

        // Random phase against the model.
        for (int k = 0; k < 6000; k++) begin
            int r = int'($urandom % 100);
            if (r < 20) begin
                src = src ^ (32'h1 << ($urandom % 32)); tick();
            end else if (r < 30) bus_read(9'h100, "R8", v);
            else if (r < 34) bus_read(9'h108, "R8", v);
            else if (r < 39) bus_read(9'h10C, "R3", v);
            else if (r < 42) bus_read(9'h110, "R5", v);
            else if (r < 44) bus_read(9'(($urandom % 64) * 4), "R2", v);
            else if (r < 51) bus_write(9'h120, $urandom);
            else if (r < 55) bus_write(9'h124, $urandom);
            else if (r < 59) bus_write(9'h128, $urandom);
            else if (r < 63) bus_write(9'h12C, $urandom & $urandom & $urandom);
            else if (r < 73) bus_write(9'h130, $urandom);
            else if (r < 79) bus_write(9'(($urandom % 32) * 4), $urandom);
            else if (r < 82) bus_write(9'h138, ($urandom % 5 == 0) ? ($urandom % 4) : 0);
            else if (r < 85) bus_write(9'h100, $urandom);
            else if (r < 86) bus_write(9'h134, $urandom);
            else tick();
            chk_irq("R7");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule